// File: doc/BRIEF.md
# Serial Boot Source Arbiter

This block decides which of two serial interfaces will carry a boot image download. Out of reset an asynchronous serial receiver and a CAN receiver are both armed and listening. The first valid event decides the channel for the rest of the boot. On the serial side any received byte counts. On the CAN side only a frame with a standard (non-extended) identifier of 0x11 and a data length of exactly eight bytes counts. Once a channel wins, the block disables the other interface, asks for that interface's pins to return to their reset configuration, and fires a single-cycle start pulse toward the matching download routine.

The block also presents the fixed configuration the receivers need. The serial divisor is the system clock divided by 1248. The CAN bit divisor is the system clock divided by 60. The CAN mailbox selection is fixed at mailbox 0. The system watchdog timeout equals 2.5 × 2^27 crystal periods. For the watchdogs, the core watchdog is held off and the system watchdog is held on until the download routine reports completion; at that point the two enables swap.

Top module: `boot_src_arb`

## Requirements
- R1: After reset, boot_mode is 2'b00 (none), uart_en and can_en are 1, uart_rx_pin_rst is 0, can_pin_rst is all zero, sys_wdt_en is 1, core_wdt_en is 0, both start pulses are 0 and boot_done is 0.
- R2: While armed, a qualifying CAN frame (can_frm_vld=1, can_frm_ext=0, can_frm_id=0x11, can_frm_dlc=8) sampled at a clock edge sets boot_mode to 2'b10 (CAN) after that edge. It also clears uart_en and sets uart_rx_pin_rst.
- R3: While armed, uart_byte_vld=1 sampled at a clock edge sets boot_mode to 2'b01 (serial) after that edge. It also clears can_en and sets every bit of can_pin_rst.
- R4: A CAN frame with a different identifier, a length other than 8, or the extended-identifier flag set is discarded: boot_mode stays 2'b00, and both interfaces stay enabled and able to win later.
- R5: When a qualifying CAN frame and a serial byte are sampled at the same edge, CAN wins (boot_mode 2'b10).
- R6: Once boot_mode is nonzero, further serial bytes and CAN frames are ignored until reset: boot_mode, the enables and the pin reset requests do not change, and no further start pulse is issued.
- R7: The decision raises exactly one start output for exactly one cycle: start_can_dl for the CAN channel and start_uart_dl for the serial channel, in the cycle after the deciding edge.
- R8: dl_done sampled at an edge after a decision sets boot_done, sets core_wdt_en and clears sys_wdt_en after that edge; dl_done while armed has no effect.
- R9: uart_baud_div reads 1248, can_bit_div reads 60, can_mbox_idx reads 0 and sys_wdt_tmo reads 335544320 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_byte_vld | input | 1 | One-cycle strobe: serial receiver got a byte |
| can_frm_vld | input | 1 | One-cycle strobe: CAN receiver got a frame |
| can_frm_ext | input | 1 | Frame used an extended identifier |
| can_frm_id | input | 11 | Standard identifier of the frame |
| can_frm_dlc | input | 4 | Data length code of the frame |
| dl_done | input | 1 | Download routine finished |
| boot_mode | output | 2 | 00 none, 01 serial, 10 CAN |
| uart_en | output | 1 | Serial receiver enable |
| can_en | output | 1 | CAN controller enable |
| uart_rx_pin_rst | output | 1 | Return serial receive pin to reset configuration |
| can_pin_rst | output | 2 | Return each CAN pin to reset configuration |
| start_uart_dl | output | 1 | One-cycle start of serial download routine |
| start_can_dl | output | 1 | One-cycle start of CAN download routine |
| boot_done | output | 1 | Boot phase finished |
| core_wdt_en | output | 1 | Core watchdog enable |
| sys_wdt_en | output | 1 | System watchdog enable |
| uart_baud_div | output | 16 | Serial baud divisor |
| can_bit_div | output | 16 | CAN bit-rate divisor |
| can_mbox_idx | output | 4 | CAN mailbox in use |
| sys_wdt_tmo | output | 32 | System watchdog timeout in crystal periods |

## Verification
A corrupted decision register shows at the ports in the very next cycle: boot_mode takes a wrong or reserved value, an enable and its pin-reset request disagree, or a start pulse appears with no event or persists. A lost or flipped finish flag shows one cycle after dl_done through the watchdog enables. Because each event is checked in the cycle after the edge that samples it, every fault in the race or the qualification becomes visible within one clock.

// File: rtl/boot_src_pkg.sv
package boot_src_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_UART = 2'b01,
        MODE_CAN  = 2'b10
    } boot_mode_e;

    typedef struct packed {
        boot_mode_e mode;
        logic       fin;
        logic       go_uart;
        logic       go_can;
    } arb_reg_t;

    localparam arb_reg_t ARB_RESET = '{mode: MODE_NONE, fin: 1'b0,
                                       go_uart: 1'b0, go_can: 1'b0};

endpackage

// File: rtl/boot_src_qual.sv
module boot_src_qual #(
    parameter int                ID_W      = 11,
    parameter int                DLC_W     = 4,
    parameter logic [ID_W-1:0]   MATCH_ID  = 11'h011,
    parameter logic [DLC_W-1:0]  MATCH_DLC = 4'd8
) (
    input  logic             frm_vld,
    input  logic             frm_ext,
    input  logic [ID_W-1:0]  frm_id,
    input  logic [DLC_W-1:0] frm_dlc,
    input  logic             byte_vld,
    output logic             can_hit,
    output logic             uart_hit
);
    logic id_ok;
    logic len_ok;

    always_comb begin
        id_ok    = (frm_id == MATCH_ID);
        len_ok   = (frm_dlc == MATCH_DLC);
        can_hit  = frm_vld & ~frm_ext & id_ok & len_ok;
        uart_hit = byte_vld;
    end
endmodule

// File: rtl/boot_src_fsm.sv
module boot_src_fsm
    import boot_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       can_hit,
    input  logic       uart_hit,
    input  logic       dl_done,
    output boot_mode_e mode,
    output logic       fin,
    output logic       go_uart,
    output logic       go_can
);
    arb_reg_t st_d;
    arb_reg_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.go_uart = 1'b0;
        st_d.go_can  = 1'b0;
        case (st_q.mode)
            MODE_NONE: begin
                // CAN takes priority on a same-cycle tie
                if (can_hit) begin
                    st_d.mode   = MODE_CAN;
                    st_d.go_can = 1'b1;
                end else if (uart_hit) begin
                    st_d.mode    = MODE_UART;
                    st_d.go_uart = 1'b1;
                end
            end
            default: begin
                if (dl_done) begin
                    st_d.fin = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ARB_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q.mode;
    assign fin     = st_q.fin;
    assign go_uart = st_q.go_uart;
    assign go_can  = st_q.go_can;
endmodule

// File: rtl/boot_src_ctl.sv
module boot_src_ctl
    import boot_src_pkg::*;
#(
    parameter int CAN_PINS = 2
) (
    input  boot_mode_e          mode,
    input  logic                fin,
    output logic                uart_en,
    output logic                can_en,
    output logic                uart_rx_pin_rst,
    output logic [CAN_PINS-1:0] can_pin_rst,
    output logic                core_wdt_en,
    output logic                sys_wdt_en
);
    logic can_lost;
    logic uart_lost;

    always_comb begin
        can_lost        = (mode == MODE_UART);
        uart_lost       = (mode == MODE_CAN);
        uart_en         = ~uart_lost;
        can_en          = ~can_lost;
        uart_rx_pin_rst = uart_lost;
        core_wdt_en     = fin;
        sys_wdt_en      = ~fin;
    end

    for (genvar p = 0; p < CAN_PINS; p++) begin : g_pin
        assign can_pin_rst[p] = can_lost;
    end
endmodule

// File: rtl/boot_src_cfg.sv
module boot_src_cfg #(
    parameter int DIV_W       = 16,
    parameter int UART_DIV    = 1248,
    parameter int CAN_DIV     = 60,
    parameter int MB_W        = 4,
    parameter int MB_SEL      = 0,
    parameter int TMO_W       = 32,
    parameter int WDT_EXP     = 27
) (
    output logic [DIV_W-1:0] uart_div,
    output logic [DIV_W-1:0] can_div,
    output logic [MB_W-1:0]  mbox,
    output logic [TMO_W-1:0] wdt_tmo
);
    // 2.5 * 2^EXP written as 5 * 2^(EXP-1)
    localparam logic [TMO_W-1:0] TMO_VAL = TMO_W'(64'd5 << (WDT_EXP - 1));

    assign uart_div = DIV_W'(UART_DIV);
    assign can_div  = DIV_W'(CAN_DIV);
    assign mbox     = MB_W'(MB_SEL);
    assign wdt_tmo  = TMO_VAL;
endmodule

// File: rtl/boot_src_arb.sv
module boot_src_arb
    import boot_src_pkg::*;
#(
    parameter int ID_W     = 11,
    parameter int DLC_W    = 4,
    parameter int CAN_PINS = 2,
    parameter int DIV_W    = 16,
    parameter int MB_W     = 4,
    parameter int TMO_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                uart_byte_vld,
    input  logic                can_frm_vld,
    input  logic                can_frm_ext,
    input  logic [ID_W-1:0]     can_frm_id,
    input  logic [DLC_W-1:0]    can_frm_dlc,
    input  logic                dl_done,
    output logic [1:0]          boot_mode,
    output logic                uart_en,
    output logic                can_en,
    output logic                uart_rx_pin_rst,
    output logic [CAN_PINS-1:0] can_pin_rst,
    output logic                start_uart_dl,
    output logic                start_can_dl,
    output logic                boot_done,
    output logic                core_wdt_en,
    output logic                sys_wdt_en,
    output logic [DIV_W-1:0]    uart_baud_div,
    output logic [DIV_W-1:0]    can_bit_div,
    output logic [MB_W-1:0]     can_mbox_idx,
    output logic [TMO_W-1:0]    sys_wdt_tmo
);
    logic       can_hit;
    logic       uart_hit;
    boot_mode_e mode;
    logic       fin;

    boot_src_qual #(
        .ID_W     (ID_W),
        .DLC_W    (DLC_W),
        .MATCH_ID (ID_W'(11'h011)),
        .MATCH_DLC(DLC_W'(8))
    ) qual_i (
        .frm_vld (can_frm_vld),
        .frm_ext (can_frm_ext),
        .frm_id  (can_frm_id),
        .frm_dlc (can_frm_dlc),
        .byte_vld(uart_byte_vld),
        .can_hit (can_hit),
        .uart_hit(uart_hit)
    );

    boot_src_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .can_hit (can_hit),
        .uart_hit(uart_hit),
        .dl_done (dl_done),
        .mode    (mode),
        .fin     (fin),
        .go_uart (start_uart_dl),
        .go_can  (start_can_dl)
    );

    boot_src_ctl #(
        .CAN_PINS(CAN_PINS)
    ) ctl_i (
        .mode           (mode),
        .fin            (fin),
        .uart_en        (uart_en),
        .can_en         (can_en),
        .uart_rx_pin_rst(uart_rx_pin_rst),
        .can_pin_rst    (can_pin_rst),
        .core_wdt_en    (core_wdt_en),
        .sys_wdt_en     (sys_wdt_en)
    );

    boot_src_cfg #(
        .DIV_W   (DIV_W),
        .UART_DIV(1248),
        .CAN_DIV (60),
        .MB_W    (MB_W),
        .MB_SEL  (0),
        .TMO_W   (TMO_W),
        .WDT_EXP (27)
    ) cfg_i (
        .uart_div(uart_baud_div),
        .can_div (can_bit_div),
        .mbox    (can_mbox_idx),
        .wdt_tmo (sys_wdt_tmo)
    );

    assign boot_mode = mode;
    assign boot_done = fin;
endmodule

// File: rtl/boot_src_arb_chk.sv
module boot_src_arb_chk #(
    parameter int ID_W     = 11,
    parameter int DLC_W    = 4,
    parameter int CAN_PINS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                uart_byte_vld,
    input logic                can_frm_vld,
    input logic                can_frm_ext,
    input logic [ID_W-1:0]     can_frm_id,
    input logic [DLC_W-1:0]    can_frm_dlc,
    input logic                dl_done,
    input logic [1:0]          boot_mode,
    input logic                uart_en,
    input logic                can_en,
    input logic                uart_rx_pin_rst,
    input logic [CAN_PINS-1:0] can_pin_rst,
    input logic                start_uart_dl,
    input logic                start_can_dl,
    input logic                core_wdt_en,
    input logic                sys_wdt_en
);
    logic good_frame;
    assign good_frame = can_frm_vld && !can_frm_ext &&
                        (can_frm_id == ID_W'(11'h011)) && (can_frm_dlc == DLC_W'(8));

    // R2: CAN channel disables the serial side
    a_r2_can_drops_uart: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode == 2'b10) |-> (!uart_en && uart_rx_pin_rst && can_en));

    // R3: serial channel disables the CAN side
    a_r3_uart_drops_can: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode == 2'b01) |-> (!can_en && (&can_pin_rst) && uart_en));

    // R5: CAN wins a tie
    a_r5_can_wins_tie: assert property (@(posedge clk) disable iff (!rst_n)
        ((boot_mode == 2'b00) && good_frame && uart_byte_vld) |=> (boot_mode == 2'b10));

    // R6: decision is sticky
    a_r6_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode != 2'b00) |=> (boot_mode == $past(boot_mode)));

    // R7: start pulses last one cycle and never overlap
    a_r7_can_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_can_dl |=> !start_can_dl);
    a_r7_uart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_uart_dl |=> !start_uart_dl);
    a_r7_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_uart_dl, start_can_dl}));

    // R8: watchdog enables swap only after a done during download
    a_r8_wdt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        core_wdt_en |-> !sys_wdt_en);
    a_r8_done_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        core_wdt_en |-> (boot_mode != 2'b00));
endmodule

bind boot_src_arb boot_src_arb_chk #(
    .ID_W    (ID_W),
    .DLC_W   (DLC_W),
    .CAN_PINS(CAN_PINS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .uart_byte_vld  (uart_byte_vld),
    .can_frm_vld    (can_frm_vld),
    .can_frm_ext    (can_frm_ext),
    .can_frm_id     (can_frm_id),
    .can_frm_dlc    (can_frm_dlc),
    .dl_done        (dl_done),
    .boot_mode      (boot_mode),
    .uart_en        (uart_en),
    .can_en         (can_en),
    .uart_rx_pin_rst(uart_rx_pin_rst),
    .can_pin_rst    (can_pin_rst),
    .start_uart_dl  (start_uart_dl),
    .start_can_dl   (start_can_dl),
    .core_wdt_en    (core_wdt_en),
    .sys_wdt_en     (sys_wdt_en)
);

// File: tb/boot_src_arb_tb_top.sv
module boot_src_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uart_byte_vld = 1'b0;
    logic        can_frm_vld = 1'b0;
    logic        can_frm_ext = 1'b0;
    logic [10:0] can_frm_id = '0;
    logic [3:0]  can_frm_dlc = '0;
    logic        dl_done = 1'b0;
    logic [1:0]  boot_mode;
    logic        uart_en, can_en, uart_rx_pin_rst;
    logic [1:0]  can_pin_rst;
    logic        start_uart_dl, start_can_dl, boot_done;
    logic        core_wdt_en, sys_wdt_en;
    logic [15:0] uart_baud_div, can_bit_div;
    logic [3:0]  can_mbox_idx;
    logic [31:0] sys_wdt_tmo;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    boot_src_arb dut_i (
        .clk(clk), .rst_n(rst_n), .uart_byte_vld(uart_byte_vld),
        .can_frm_vld(can_frm_vld), .can_frm_ext(can_frm_ext),
        .can_frm_id(can_frm_id), .can_frm_dlc(can_frm_dlc), .dl_done(dl_done),
        .boot_mode(boot_mode), .uart_en(uart_en), .can_en(can_en),
        .uart_rx_pin_rst(uart_rx_pin_rst), .can_pin_rst(can_pin_rst),
        .start_uart_dl(start_uart_dl), .start_can_dl(start_can_dl),
        .boot_done(boot_done), .core_wdt_en(core_wdt_en), .sys_wdt_en(sys_wdt_en),
        .uart_baud_div(uart_baud_div), .can_bit_div(can_bit_div),
        .can_mbox_idx(can_mbox_idx), .sys_wdt_tmo(sys_wdt_tmo)
    );

    // vector: {uart, can_vld, ext, id[10:0], dlc[3:0], exp_mode[1:0]}
    localparam logic [19:0] VEC [8] = '{
        {1'b1, 1'b0, 1'b0, 11'h000, 4'd0, 2'b01},  // R3 serial byte alone
        {1'b0, 1'b1, 1'b0, 11'h011, 4'd8, 2'b10},  // R2 good frame
        {1'b1, 1'b1, 1'b0, 11'h011, 4'd8, 2'b10},  // R5 tie
        {1'b0, 1'b1, 1'b0, 11'h012, 4'd8, 2'b00},  // R4 wrong id
        {1'b0, 1'b1, 1'b0, 11'h011, 4'd7, 2'b00},  // R4 wrong length
        {1'b0, 1'b1, 1'b1, 11'h011, 4'd8, 2'b00},  // R4 extended id
        {1'b1, 1'b1, 1'b0, 11'h111, 4'd8, 2'b01},  // R4 bad frame, serial wins
        {1'b0, 1'b0, 1'b0, 11'h011, 4'd8, 2'b00}   // no strobe
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        uart_byte_vld = 1'b0; can_frm_vld = 1'b0; can_frm_ext = 1'b0;
        can_frm_id = '0; can_frm_dlc = '0; dl_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic u, input logic cv, input logic ext,
                             input logic [10:0] id, input logic [3:0] dlc);
        uart_byte_vld = u; can_frm_vld = cv; can_frm_ext = ext;
        can_frm_id = id; can_frm_dlc = dlc;
        @(negedge clk);
        uart_byte_vld = 1'b0; can_frm_vld = 1'b0; can_frm_ext = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 mode", 32'(boot_mode), 0);
        chk("R1 enables", {30'd0, uart_en, can_en}, 32'h3);
        chk("R1 pin rst", {29'd0, uart_rx_pin_rst, can_pin_rst}, 0);
        chk("R1 wdt", {30'd0, sys_wdt_en, core_wdt_en}, 32'h2);
        chk("R1 starts", {29'd0, start_uart_dl, start_can_dl, boot_done}, 0);

        // table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < 8; i++) begin
            logic [19:0] v;
            v = VEC[i];
            do_reset();
            pulse_evt(v[19], v[18], v[17], v[16:6], v[5:2]);
            chk($sformatf("R2/R3/R4/R5 vec%0d mode", i), 32'(boot_mode), 32'(v[1:0]));
            chk($sformatf("R7 vec%0d start_can", i), 32'(start_can_dl), 32'(v[1:0] == 2'b10));
            chk($sformatf("R7 vec%0d start_uart", i), 32'(start_uart_dl), 32'(v[1:0] == 2'b01));
            if (v[1:0] == 2'b10) begin
                chk("R2 uart off, rx pin rst", {30'd0, uart_en, uart_rx_pin_rst}, 32'h1);
                chk("R2 can stays on", 32'(can_en), 1);
            end
            if (v[1:0] == 2'b01) begin
                chk("R3 can off, pins rst", {29'd0, can_en, can_pin_rst}, 32'h3);
                chk("R3 uart stays on", 32'(uart_en), 1);
            end
            if (v[1:0] == 2'b00) begin
                chk("R4 still armed", {30'd0, uart_en, can_en}, 32'h3);
            end
            @(negedge clk);
            chk($sformatf("R7 vec%0d pulse gone", i), {30'd0, start_uart_dl, start_can_dl}, 0);
        end

        // R4: after a discarded frame the serial side can still win later
        do_reset();
        pulse_evt(1'b0, 1'b1, 1'b0, 11'h011, 4'd3);
        @(negedge clk);
        pulse_evt(1'b1, 1'b0, 1'b0, 11'h000, 4'd0);
        chk("R4 later serial byte wins", 32'(boot_mode), 32'h1);

        // R6: events after lock are ignored
        @(negedge clk);
        pulse_evt(1'b0, 1'b1, 1'b0, 11'h011, 4'd8);
        chk("R6 mode kept", 32'(boot_mode), 32'h1);
        chk("R6 no new start", {30'd0, start_uart_dl, start_can_dl}, 0);
        chk("R6 can stays off", {29'd0, can_en, can_pin_rst}, 32'h3);
        pulse_evt(1'b1, 1'b0, 1'b0, 11'h000, 4'd0);
        chk("R6 no second serial start", 32'(start_uart_dl), 0);

        // R8: done while armed is ignored
        do_reset();
        dl_done = 1'b1;
        @(negedge clk);
        dl_done = 1'b0;
        chk("R8 done ignored when armed", {29'd0, boot_done, core_wdt_en, sys_wdt_en}, 32'h1);
        // R8: done after a CAN lock
        pulse_evt(1'b0, 1'b1, 1'b0, 11'h011, 4'd8);
        chk("R8 before done", {29'd0, boot_done, core_wdt_en, sys_wdt_en}, 32'h1);
        dl_done = 1'b1;
        @(negedge clk);
        dl_done = 1'b0;
        chk("R8 after done", {29'd0, boot_done, core_wdt_en, sys_wdt_en}, 32'h6);
        chk("R8 mode kept after done", 32'(boot_mode), 32'h2);
        pulse_evt(1'b1, 1'b0, 1'b0, 11'h000, 4'd0);
        chk("R6 serial ignored after done", {29'd0, start_uart_dl, boot_mode}, 32'h2);

        // R9 fixed configuration
        chk("R9 uart div", 32'(uart_baud_div), 1248);
        chk("R9 can div", 32'(can_bit_div), 60);
        chk("R9 mailbox", 32'(can_mbox_idx), 0);
        chk("R9 wdt timeout", sys_wdt_tmo, 32'd335544320);

        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule